// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Adapter

This block sits on the receive side of a 10/100 Ethernet port. It takes the 4-bit receive bus from the PHY, together with its data-valid and error strobes, and produces a byte stream with frame markers. It discards the preamble. It locks byte alignment on the start-of-frame delimiter. It pairs the nibbles that follow into bytes. When the frame ends it reports three things: an error seen during the frame, a frame length outside the legal Ethernet range, and an odd count of data nibbles.

The whole block runs on the receive clock driven by the PHY. It has no timers and no rate setting, so the same logic serves the slow and the fast line rate. Carrier sense and collision are not used for framing. They are only retimed into the receive clock domain and passed on as status bits.

Top module: `mii_rx_byte_adapter`

## Requirements
- R1: While the valid strobe is high, the block discards nibbles until it sees the nibble 0x5 followed directly by the nibble 0xD. The nibble after the 0xD is the first data nibble. A frame that never shows this pair produces no byte, no start marker and no end marker.
- R2: The first data nibble of each pair is bits 3:0 of the byte and the second is bits 7:4. `out_valid` is high for exactly one cycle, in the cycle after the edge that samples the second nibble, with the byte on `out_byte`.
- R3: `out_sof` is high together with `out_valid` on the first byte of a frame, and only then.
- R4: `out_eof` is a one-cycle pulse. It is high in the cycle after the first edge that samples the valid strobe low once data nibbles have started, and `out_valid` is low in that cycle.
- R5: Nibbles and the error input sampled while the valid strobe is low have no effect on any output.
- R6: `frm_err` rises in the cycle after an edge that samples `rx_error` high with `rx_valid` high, including during the preamble. It stays high up to and including the `out_eof` cycle and is low in the cycle after, unless a new error arrives.
- R7: During the `out_eof` cycle, `len_err` is high when the frame held fewer than MIN_LEN (default 64) or more than MAX_LEN (default 1518) complete bytes. It is low when the count is within that range, and low in every other cycle.
- R8: When the valid strobe falls after an odd number of data nibbles, the trailing nibble is not output and `align_err` is high during the `out_eof` cycle. It is low otherwise.
- R9: `carrier_sync` and `collision_sync` follow `carrier_in` and `collision_in` through SYNC_STAGES (default 2) flip-flops, so a change appears after that many clock edges.
- R10: Frames separated by a single idle cycle are each framed, counted and delimited independently.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock supplied by the PHY |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_nib | input | 4 | Receive data nibble |
| rx_valid | input | 1 | Receive data valid, spans the whole frame |
| rx_error | input | 1 | Receive error strobe from the PHY |
| carrier_in | input | 1 | Carrier activity, asynchronous |
| collision_in | input | 1 | Collision indication, asynchronous |
| out_byte | output | 8 | Assembled byte |
| out_valid | output | 1 | Byte strobe |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | End-of-frame pulse carrying the flags |
| frm_err | output | 1 | Sticky frame error |
| len_err | output | 1 | Frame length outside limits, valid with out_eof |
| align_err | output | 1 | Odd nibble count, valid with out_eof |
| carrier_sync | output | 1 | Retimed carrier status |
| collision_sync | output | 1 | Retimed collision status |

## Verification
Two pairs of functions can report in the same cycle. In the first, an error is raised on the nibble that completes the last byte, so the byte strobe and the rising frame-error flag appear together. The bench then expects the flag to last through the end marker and clear on the next cycle. In the second, a 63-byte frame ends with an extra nibble, so the length and alignment flags must both be high in the one end-of-frame cycle while the orphan nibble is dropped. Both cases are judged against byte counts and flag values the bench predicts from the nibble stream it drives.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

endpackage

// File: rtl/mii_rx_status_sync.sv
module mii_rx_status_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              dv_i,
  input  logic              er_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sof_o,
  output logic              end_now_o,
  output logic              end_o,
  output logic              odd_o,
  output logic              err_o
);

  rx_state_e         st_q, st_d;
  logic              half_q, half_d;
  logic              pre5_q, pre5_d;
  logic              first_q, first_d;
  logic [NIB_W-1:0]  low_q;
  logic              low_ld;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_ld;
  logic              vld_q, vld_d;
  logic              sof_q, sof_d;
  logic              end_q, end_d;
  logic              odd_q, odd_d;
  logic              err_q, err_d;
  logic              err_clr;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    half_d   = half_q;
    pre5_d   = pre5_q;
    first_d  = first_q;
    low_ld   = 1'b0;
    byte_ld  = 1'b0;
    vld_d    = 1'b0;
    sof_d    = 1'b0;
    end_d    = 1'b0;
    odd_d    = 1'b0;
    end_now_o = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (dv_i) begin
          st_d   = ST_HUNT;
          pre5_d = (nib_i == PRE_NIB);
        end
      end
      ST_HUNT: begin
        if (!dv_i) begin
          st_d = ST_IDLE;
        end else if (pre5_q && nib_i == SFD_NIB) begin
          st_d    = ST_DATA;
          half_d  = 1'b0;
          first_d = 1'b1;
        end else begin
          pre5_d = (nib_i == PRE_NIB);
        end
      end
      ST_DATA: begin
        if (!dv_i) begin
          st_d      = ST_IDLE;
          end_d     = 1'b1;
          end_now_o = 1'b1;
          odd_d     = half_q;
          half_d    = 1'b0;
        end else if (!half_q) begin
          low_ld = 1'b1;
          half_d = 1'b1;
        end else begin
          byte_ld = 1'b1;
          vld_d   = 1'b1;
          sof_d   = first_q;
          first_d = 1'b0;
          half_d  = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    err_clr = end_q || (!dv_i && st_q != ST_DATA);
    err_d   = (err_clr ? 1'b0 : err_q) | (dv_i & er_i);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      half_q  <= 1'b0;
      pre5_q  <= 1'b0;
      first_q <= 1'b0;
      vld_q   <= 1'b0;
      sof_q   <= 1'b0;
      end_q   <= 1'b0;
      odd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      half_q  <= half_d;
      pre5_q  <= pre5_d;
      first_q <= first_d;
      vld_q   <= vld_d;
      sof_q   <= sof_d;
      end_q   <= end_d;
      odd_q   <= odd_d;
      err_q   <= err_d;
    end
  end

  // data registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_ld) low_q <= nib_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_ld) byte_q <= {nib_i, low_q};
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign sof_o      = sof_q;
  assign end_o      = end_q;
  assign odd_o      = odd_q;
  assign err_o      = err_q;

  // R3: the start marker only rides on a byte strobe
  p_sof_with_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> vld_q);

  // R2: two nibbles per byte, so strobes never sit in adjacent cycles
  p_byte_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R4: end marker is a lone pulse without a byte
  p_eof_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !vld_q);

  p_eof_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q);

  // R5: a byte can only come from a nibble sampled with valid high
  p_byte_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(dv_i));

  // R6: error stays set while the frame continues
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !end_q && dv_i) |=> err_q);

  // R6: error drops after the end marker unless a new one arrives
  p_err_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !(dv_i && er_i)) |=> !err_q);

endmodule

// File: rtl/mii_rx_len_check.sv
module mii_rx_len_check #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_i,
  input  logic end_i,
  output logic len_err_o
);

  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_LEN + 1);
  localparam logic [CNT_W:0]   MIN_V = (CNT_W+1)'(MIN_LEN);
  localparam logic [CNT_W:0]   MAX_V = (CNT_W+1)'(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   total;
  logic             len_err_q, len_err_d;

  always_comb begin
    total = {1'b0, cnt_q} + {{CNT_W{1'b0}}, byte_i};
    cnt_d = cnt_q;
    if (end_i)
      cnt_d = '0;
    else if (byte_i && cnt_q != SAT_V)
      cnt_d = cnt_q + 1'b1;
    len_err_d = end_i && ((total < MIN_V) || (total > MAX_V));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      len_err_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      len_err_q <= len_err_d;
    end
  end

  assign len_err_o = len_err_q;

  // R7: counter saturates just above the legal maximum
  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_V);

  // R7: count restarts for each frame
  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> cnt_q == '0);

endmodule

// File: rtl/mii_rx_byte_adapter.sv
module mii_rx_byte_adapter
  import mii_rx_pkg::*;
#(
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1518,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rx_nib,
  input  logic       rx_valid,
  input  logic       rx_error,
  input  logic       carrier_in,
  input  logic       collision_in,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic       frm_err,
  output logic       len_err,
  output logic       align_err,
  output logic       carrier_sync,
  output logic       collision_sync
);

  logic rst_meta_q, rst_int_n;
  logic end_now;
  logic [1:0] status_sync;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  mii_rx_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .nib_i      (rx_nib),
    .dv_i       (rx_valid),
    .er_i       (rx_error),
    .byte_o     (out_byte),
    .byte_vld_o (out_valid),
    .sof_o      (out_sof),
    .end_now_o  (end_now),
    .end_o      (out_eof),
    .odd_o      (align_err),
    .err_o      (frm_err)
  );

  mii_rx_len_check #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_len (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .byte_i    (out_valid),
    .end_i     (end_now),
    .len_err_o (len_err)
  );

  mii_rx_status_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({collision_in, carrier_in}),
    .sync_o  (status_sync)
  );

  assign carrier_sync   = status_sync[0];
  assign collision_sync = status_sync[1];

  // R7: the length flag is only raised with the end marker
  p_len_at_eof_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    len_err |-> out_eof);

  // R8: the alignment flag is only raised with the end marker
  p_align_at_eof_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    align_err |-> out_eof);

endmodule

// File: tb/mii_rx_byte_adapter_test.sv
module mii_rx_byte_adapter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rx_nib;
  logic       rx_valid, rx_error, carrier_in, collision_in;
  logic [7:0] out_byte;
  logic       out_valid, out_sof, out_eof, frm_err, len_err, align_err;
  logic       carrier_sync, collision_sync;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mii_rx_byte_adapter uut (
    .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .rx_valid(rx_valid),
    .rx_error(rx_error), .carrier_in(carrier_in), .collision_in(collision_in),
    .out_byte(out_byte), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .frm_err(frm_err), .len_err(len_err),
    .align_err(align_err), .carrier_sync(carrier_sync),
    .collision_sync(collision_sync)
  );

  // capture of output activity
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  int  sof_cnt, sof_bad, eof_cnt;
  bit  eof_err, eof_len, eof_align, eof_after_byte, err_after, after_eof, prev_valid;

  always @(negedge clk) begin
    if (out_sof) begin
      sof_cnt++;
      if (!out_valid) sof_bad++;
    end
    if (out_valid) begin
      got.push_back(out_byte);
      if (out_sof && (got.size() != 1) && (eof_cnt == 0)) sof_bad++;
    end
    if (after_eof) begin
      err_after = frm_err;
      after_eof = 1'b0;
    end
    if (out_eof) begin
      eof_cnt++;
      eof_err = frm_err;
      eof_len = len_err;
      eof_align = align_err;
      eof_after_byte = prev_valid;
      after_eof = 1'b1;
    end
    prev_valid = out_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_capture();
    got.delete();
    exp_q.delete();
    sof_cnt = 0; sof_bad = 0; eof_cnt = 0;
    eof_err = 0; eof_len = 0; eof_align = 0; eof_after_byte = 0;
    err_after = 0; after_eof = 0;
  endtask

  task automatic drive(input logic [3:0] n, input logic dv, input logic er);
    @(negedge clk);
    rx_nib = n; rx_valid = dv; rx_error = er;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(4'h0, 1'b0, 1'b0);
  endtask

  // err_nib: index of the data nibble carrying rx_error, -1 for none
  task automatic send_frame(input int nbytes, input int seed, input int pre_n,
                            input int err_nib, input bit extra, input int gap);
    for (int i = 0; i < pre_n; i++) drive(4'h5, 1'b1, 1'b0);
    drive(4'hD, 1'b1, 1'b0);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] v;
      v = 8'((b * 37 + seed) & 255);
      exp_q.push_back(v);
      drive(v[3:0], 1'b1, (2*b) == err_nib);
      drive(v[7:4], 1'b1, (2*b+1) == err_nib);
    end
    if (extra) drive(4'h9, 1'b1, 1'b0);
    idle(gap);
  endtask

  task automatic check_frame(input string tag, input bit x_err, input bit x_len,
                             input bit x_align);
    int mism = 0;
    check(got.size() == exp_q.size(), {tag, " byte count"}, got.size(), exp_q.size());
    if (got.size() == exp_q.size())
      foreach (got[i]) if (got[i] !== exp_q[i]) mism++;
    check(mism == 0, {tag, " R2 byte content"}, mism, 0);
    check(sof_cnt == 1 && sof_bad == 0, {tag, " R3 start marker"}, sof_cnt, 1);
    check(eof_cnt == 1, {tag, " R4 end marker"}, eof_cnt, 1);
    if (!x_align)
      check(eof_after_byte, {tag, " R4 end follows last byte"}, eof_after_byte, 1);
    check(eof_err == x_err, {tag, " R6 frame error at end"}, eof_err, x_err);
    check(err_after == 1'b0, {tag, " R6 frame error clears"}, err_after, 0);
    check(eof_len == x_len, {tag, " R7 length flag"}, eof_len, x_len);
    check(eof_align == x_align, {tag, " R8 alignment flag"}, eof_align, x_align);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rx_nib = '0; rx_valid = 0; rx_error = 0;
    carrier_in = 0; collision_in = 0;
    clear_capture();
    repeat (3) @(negedge clk);
    check({out_byte, out_valid, out_sof, out_eof, frm_err, len_err, align_err,
           carrier_sync, collision_sync} == '0, "R11 reset outputs", out_valid, 0);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_min_frame();
    clear_capture();
    send_frame(64, 3, 15, -1, 0, 4);
    check_frame("R1 R7 64-byte", 0, 0, 0);
  endtask

  task automatic t_short_sfd();
    clear_capture();
    send_frame(64, 11, 1, -1, 0, 4);
    check_frame("R1 minimal preamble", 0, 0, 0);
  endtask

  task automatic t_len_limits();
    clear_capture(); send_frame(63, 5, 15, -1, 0, 4);
    check_frame("R7 63-byte", 0, 1, 0);
    clear_capture(); send_frame(1518, 7, 15, -1, 0, 4);
    check_frame("R7 1518-byte", 0, 0, 0);
    clear_capture(); send_frame(1519, 9, 15, -1, 0, 4);
    check_frame("R7 1519-byte", 0, 1, 0);
  endtask

  task automatic t_odd_nibble();
    clear_capture(); send_frame(100, 13, 15, -1, 1, 4);
    check_frame("R8 odd nibble", 0, 0, 1);
    clear_capture(); send_frame(63, 17, 15, -1, 1, 4);
    check_frame("R7 R8 short and odd", 0, 1, 1);
  endtask

  task automatic t_err_last();
    clear_capture(); send_frame(70, 19, 15, 139, 0, 4);
    check_frame("R6 error on last nibble", 1, 0, 0);
  endtask

  task automatic t_err_timing();
    clear_capture();
    drive(4'h5, 1, 0); drive(4'hD, 1, 0);
    drive(4'h1, 1, 0); drive(4'h2, 1, 0);
    check(frm_err == 0, "R6 no error before strobe", frm_err, 0);
    drive(4'h3, 1, 1);
    drive(4'h4, 1, 0);
    check(frm_err == 1, "R6 error rises next cycle", frm_err, 1);
    for (int i = 0; i < 6; i++) drive(4'h6, 1, 0);
    check(frm_err == 1, "R6 error sticky", frm_err, 1);
    idle(4);
    check(eof_cnt == 1 && eof_err == 1 && err_after == 0, "R6 error spans end then clears",
          err_after, 0);
  endtask

  task automatic t_ignored();
    clear_capture();
    for (int i = 0; i < 8; i++) drive(i[0] ? 4'hD : 4'h5, 1'b0, 1'b1);
    idle(3);
    check(got.size() == 0 && eof_cnt == 0, "R5 no output with valid low", got.size(), 0);
    check(frm_err == 0, "R5 error ignored with valid low", frm_err, 0);
  endtask

  task automatic t_no_sfd();
    clear_capture();
    drive(4'h5, 1, 0); drive(4'hA, 1, 0); drive(4'h5, 1, 0); drive(4'h3, 1, 0);
    drive(4'hD, 1, 0); drive(4'h5, 1, 0); drive(4'h5, 1, 0); drive(4'hE, 1, 0);
    idle(4);
    check(got.size() == 0 && eof_cnt == 0 && sof_cnt == 0, "R1 no frame without delimiter",
          eof_cnt, 0);
  endtask

  task automatic t_back_to_back();
    clear_capture();
    send_frame(64, 23, 7, -1, 0, 1);
    send_frame(65, 29, 7, -1, 0, 4);
    check(eof_cnt == 2, "R10 two end markers", eof_cnt, 2);
    check(sof_cnt == 2, "R10 two start markers", sof_cnt, 2);
    check(got.size() == 129, "R10 byte total", got.size(), 129);
    check(eof_len == 0, "R10 second frame length ok", eof_len, 0);
  endtask

  task automatic t_sync();
    @(negedge clk); carrier_in = 1; collision_in = 1;
    @(negedge clk);
    check(carrier_sync == 0 && collision_sync == 0, "R9 not yet after one edge", carrier_sync, 0);
    @(negedge clk);
    check(carrier_sync == 1 && collision_sync == 1, "R9 set after two edges", carrier_sync, 1);
    collision_in = 0;
    @(negedge clk); @(negedge clk);
    check(carrier_sync == 1 && collision_sync == 0, "R9 independent bits", collision_sync, 0);
  endtask

  initial begin
    t_reset();
    t_min_frame();
    t_short_sfd();
    t_len_limits();
    t_odd_nibble();
    t_err_last();
    t_err_timing();
    t_ignored();
    t_no_sfd();
    t_back_to_back();
    t_sync();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule